// File: doc/BRIEF.md
# Link Power Management Handshake Responder (Device Side)

This block sits in a USB device controller next to the token decoder. When a Link Power Management token arrives, it decides which handshake the device sends back (ACK, NYET or STALL). It also pulses a capture strobe so that the token payload is latched into the attribute register kept elsewhere. Each outcome is recorded as a sticky bit in an eight-bit raw interrupt status register, and reading that register clears it.

The reply depends on four things: the two-bit enable setting, the transmit-LPM control bit, the pending-data flags of the transmit and receive FIFOs, and the requested link state carried in the token. Only link state value 1 is supported. Any other value is refused with STALL and flagged as an error, but its payload is still captured so that software can inspect it. A resume event from the suspend logic sets its own status bit. Physical signalling and suspend sequencing live outside this block.

Top module: `lpmr_responder`

## Requirements
- R1: After reset, `hs_valid`, `attr_capture`, `hs_code` and `stat` are all zero. `hs_code` is zero in every cycle where `hs_valid` is low.
- R2: With `lpm_mode` = 1 and a supported link state, a token is answered with STALL (`hs_code` = 3) and sets `stat[0]`.
- R3: With `lpm_mode` = 3 and `tx_lpm` = 0, a token is answered with NYET (`hs_code` = 2) and sets `stat[1]`, whatever the FIFO flags are.
- R4: With `lpm_mode` = 3, `tx_lpm` = 1 and neither FIFO flag set, a token is answered with ACK (`hs_code` = 1) and sets `stat[2]`.
- R5: With `lpm_mode` = 3, `tx_lpm` = 1 and `rx_pending` = 1, a token is answered with NYET and sets `stat[3]`. This holds even when `tx_pending` is also set.
- R6: With `lpm_mode` = 3, `tx_lpm` = 1, `tx_pending` = 1 and `rx_pending` = 0, a token is answered with NYET and sets `stat[1]`.
- R7: In `lpm_mode` 1 or 3, a token whose link state is not 1 is answered with STALL and sets only `stat[5]`. This check takes priority over every mode-based choice.
- R8: Every answered token raises `attr_capture` for exactly the cycle in which `hs_valid` is high. That cycle is the one after `tok_valid`.
- R9: With `lpm_mode` 0 or 2, tokens are ignored: no handshake, no capture, and no status bit changes.
- R10: A `resume_evt` pulse sets `stat[4]` in the following cycle.
- R11: A cycle with `stat_rd` high clears every status bit at the next edge. An event arriving in that same cycle is kept. `stat[7:6]` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | One-cycle strobe: an LPM token was received |
| tok_link_state | input | LS_W | Requested link state field of the token |
| lpm_mode | input | 2 | Enable setting: 0/2 ignore, 1 always STALL, 3 full handshake |
| tx_lpm | input | 1 | Transmit-LPM control: 1 permits ACK |
| tx_pending | input | 1 | Transmit FIFOs hold data |
| rx_pending | input | 1 | Receive FIFOs hold data |
| resume_evt | input | 1 | One-cycle resume event |
| stat_rd | input | 1 | Status register read strobe (clears on the next edge) |
| hs_valid | output | 1 | Handshake is to be sent this cycle |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NYET, 3 STALL |
| attr_capture | output | 1 | Latch the token payload into the attribute register |
| stat | output | 8 | Raw interrupt status register value |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a new token. In that case the clear and the set meet at one edge, and the bench must show that the new bit survives. The stimulus raises `stat_rd` and `tok_valid` together on one falling edge. It first checks that the read returns the old contents, then checks that a second read returns only the new STALL bit. The priority of the error path is covered by sending unsupported link states in both STALL-only mode and in ACK-eligible mode with both FIFO flags set.

// File: rtl/lpmr_pkg.sv
// Shared types for the LPM handshake responder.
// Assumes the status bit positions below are fixed, because software decodes them.
package lpmr_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NYET  = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    localparam int BIT_STALL  = 0;
    localparam int BIT_NYET   = 1;
    localparam int BIT_ACK    = 2;
    localparam int BIT_NOCMP  = 3;
    localparam int BIT_RESUME = 4;
    localparam int BIT_ERR    = 5;
    localparam int NUM_EVT    = 6;
endpackage

// File: rtl/lpmr_classify.sv
// Combinational reply selection for one received LPM token.
// Assumes tok_valid is a single-cycle strobe and that all other inputs are
// stable in that cycle. Modes with bit 0 clear do not answer.
module lpmr_classify
    import lpmr_pkg::*;
#(
    parameter int LS_W         = 4,
    parameter int SUPPORTED_LS = 1
) (
    input  logic                tok_valid,
    input  logic [LS_W-1:0]     tok_link_state,
    input  logic [1:0]          lpm_mode,
    input  logic                tx_lpm,
    input  logic                tx_pending,
    input  logic                rx_pending,
    output logic                answer,
    output hs_e                 reply,
    output logic [NUM_EVT-1:0]  evt
);
    localparam logic [LS_W-1:0] LS_OK = LS_W'(SUPPORTED_LS);

    // Pick a handshake: the error check comes first, then the enable mode, then FIFO state.
    always_comb begin
        answer = 1'b0;
        reply  = HS_NONE;
        evt    = '0;
        if (tok_valid && lpm_mode[0]) begin
            answer = 1'b1;
            if (tok_link_state != LS_OK) begin
                reply        = HS_STALL;
                evt[BIT_ERR] = 1'b1;
            end else if (!lpm_mode[1]) begin
                reply          = HS_STALL;
                evt[BIT_STALL] = 1'b1;
            end else if (!tx_lpm) begin
                reply         = HS_NYET;
                evt[BIT_NYET] = 1'b1;
            end else if (rx_pending) begin
                reply          = HS_NYET;
                evt[BIT_NOCMP] = 1'b1;
            end else if (tx_pending) begin
                reply         = HS_NYET;
                evt[BIT_NYET] = 1'b1;
            end else begin
                reply        = HS_ACK;
                evt[BIT_ACK] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpmr_reply_reg.sv
// Registers the chosen handshake and the payload capture strobe.
// Assumes reply is HS_NONE whenever answer is low.
module lpmr_reply_reg
    import lpmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       answer,
    input  hs_e        reply,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    output logic       attr_capture
);
    // Hold one cycle of reply toward the packet encoder and the attribute register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid     <= 1'b0;
            hs_code      <= 2'd0;
            attr_capture <= 1'b0;
        end else begin
            hs_valid     <= answer;
            hs_code      <= answer ? reply : HS_NONE;
            attr_capture <= answer;
        end
    end
endmodule

// File: rtl/lpmr_status.sv
// Sticky raw interrupt status register that clears on read.
// Assumes rd is a single-cycle strobe. A set arriving in the read cycle survives the clear.
module lpmr_status #(
    parameter int STAT_W = 8,
    parameter int EVT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  set_evt,
    input  logic              rd,
    output logic [STAT_W-1:0] stat
);
    generate
        for (genvar i = 0; i < STAT_W; i++) begin : g_bit
            if (i < EVT_W) begin : g_live
                // Per-bit sticky flag: set by its event, cleared by a read.
                always_ff @(posedge clk) begin
                    if (!rst_n) stat[i] <= 1'b0;
                    else        stat[i] <= (stat[i] & ~rd) | set_evt[i];
                end
            end else begin : g_rsvd
                assign stat[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/lpmr_responder.sv
// Top level of the device-side LPM handshake responder.
// Assumes the tokens come from a decoder that checks CRC, and that the
// handshake is sent the cycle after tok_valid.
module lpmr_responder
    import lpmr_pkg::*;
#(
    parameter int LS_W         = 4,
    parameter int SUPPORTED_LS = 1,
    parameter int STAT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [LS_W-1:0]   tok_link_state,
    input  logic [1:0]        lpm_mode,
    input  logic              tx_lpm,
    input  logic              tx_pending,
    input  logic              rx_pending,
    input  logic              resume_evt,
    input  logic              stat_rd,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              attr_capture,
    output logic [STAT_W-1:0] stat
);
    logic               answer;
    hs_e                reply;
    logic [NUM_EVT-1:0] tok_evt;
    logic [NUM_EVT-1:0] all_evt;

    lpmr_classify #(.LS_W(LS_W), .SUPPORTED_LS(SUPPORTED_LS)) u_classify (
        .tok_valid(tok_valid), .tok_link_state(tok_link_state), .lpm_mode(lpm_mode),
        .tx_lpm(tx_lpm), .tx_pending(tx_pending), .rx_pending(rx_pending),
        .answer(answer), .reply(reply), .evt(tok_evt)
    );

    lpmr_reply_reg u_reply (
        .clk(clk), .rst_n(rst_n), .answer(answer), .reply(reply),
        .hs_valid(hs_valid), .hs_code(hs_code), .attr_capture(attr_capture)
    );

    // Merge the resume event into the token-driven event vector.
    always_comb begin
        all_evt             = tok_evt;
        all_evt[BIT_RESUME] = resume_evt;
    end

    lpmr_status #(.STAT_W(STAT_W), .EVT_W(NUM_EVT)) u_status (
        .clk(clk), .rst_n(rst_n), .set_evt(all_evt), .rd(stat_rd), .stat(stat)
    );
endmodule

// File: rtl/lpmr_responder_chk.sv
// Property checker for lpmr_responder, attached with bind.
// Assumes the default status layout (error bit 5, resume bit 4, reserved bits 7:6).
module lpmr_responder_chk #(
    parameter int LS_W         = 4,
    parameter int SUPPORTED_LS = 1,
    parameter int STAT_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [LS_W-1:0]   tok_link_state,
    input logic [1:0]        lpm_mode,
    input logic              resume_evt,
    input logic              stat_rd,
    input logic              hs_valid,
    input logic [1:0]        hs_code,
    input logic              attr_capture,
    input logic [STAT_W-1:0] stat
);
    a_r1_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_valid |-> hs_code == 2'd0);
    a_r2_stall_mode: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && lpm_mode == 2'd1 |=> hs_valid && hs_code == 2'd3);
    a_r7_error_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && lpm_mode[0] && tok_link_state != LS_W'(SUPPORTED_LS)
        |=> hs_code == 2'd3 && stat[5]);
    a_r8_capture_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        attr_capture == hs_valid);
    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !lpm_mode[0] |=> !hs_valid && !attr_capture);
    a_r10_resume: assert property (@(posedge clk) disable iff (!rst_n)
        resume_evt |=> stat[4]);
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !tok_valid && !resume_evt |=> stat == '0);
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        stat[7:6] == 2'b00);
endmodule

bind lpmr_responder lpmr_responder_chk #(
    .LS_W(LS_W), .SUPPORTED_LS(SUPPORTED_LS), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_link_state(tok_link_state),
    .lpm_mode(lpm_mode), .resume_evt(resume_evt), .stat_rd(stat_rd),
    .hs_valid(hs_valid), .hs_code(hs_code), .attr_capture(attr_capture), .stat(stat)
);

// File: tb/tb_lpmr_responder.sv
`timescale 1ns/1ps
module tb_lpmr_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [3:0] tok_link_state = 4'd1;
    logic [1:0] lpm_mode = 2'd0;
    logic       tx_lpm = 1'b0, tx_pending = 1'b0, rx_pending = 1'b0;
    logic       resume_evt = 1'b0, stat_rd = 1'b0;
    logic       hs_valid, attr_capture;
    logic [1:0] hs_code;
    logic [7:0] stat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    lpmr_responder dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_link_state(tok_link_state),
        .lpm_mode(lpm_mode), .tx_lpm(tx_lpm), .tx_pending(tx_pending), .rx_pending(rx_pending),
        .resume_evt(resume_evt), .stat_rd(stat_rd), .hs_valid(hs_valid), .hs_code(hs_code),
        .attr_capture(attr_capture), .stat(stat)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop the expected handshakes as the design produces them (R8 capture too).
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && hs_valid) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected handshake", {6'd0, hs_code}, 8'd0);
                end else begin
                    logic [1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {6'd0, hs_code}, {6'd0, e});
                    check("R8 capture with handshake", {7'd0, attr_capture}, 8'd1);
                end
            end
        end
    end

    // Driver: one token. exp = 0 means the token must be ignored.
    task automatic send(input logic [1:0] m, input logic tx, input logic txp, input logic rxp,
                        input logic [3:0] ls, input logic [1:0] exp, input string tag);
        @(negedge clk);
        lpm_mode = m; tx_lpm = tx; tx_pending = txp; rx_pending = rxp;
        tok_link_state = ls; tok_valid = 1'b1;
        if (exp != 2'd0) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        tok_valid = 1'b0;
        if (exp == 2'd0) begin
            check({tag, " no handshake"}, {7'd0, hs_valid}, 8'd0);
            check({tag, " no capture"}, {7'd0, attr_capture}, 8'd0);
        end
    endtask

    task automatic read_expect(input logic [7:0] exp, input string tag);
        @(negedge clk);
        stat_rd = 1'b1;
        #1 check(tag, stat, exp);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset hs_valid", {7'd0, hs_valid}, 8'd0);
        check("R1 reset capture", {7'd0, attr_capture}, 8'd0);
        check("R1 reset code", {6'd0, hs_code}, 8'd0);
        check("R1 reset stat", stat, 8'd0);
        mon_on = 1'b1;

        send(2'd1, 1'b0, 1'b0, 1'b0, 4'd1, 2'd3, "R2 stall mode");
        read_expect(8'h01, "R2 stat");
        read_expect(8'h00, "R11 cleared after read");

        send(2'd3, 1'b0, 1'b1, 1'b1, 4'd1, 2'd2, "R3 nyet tx_lpm=0");
        read_expect(8'h02, "R3 stat");

        send(2'd3, 1'b1, 1'b0, 1'b0, 4'd1, 2'd1, "R4 ack");
        read_expect(8'h04, "R4 stat");

        send(2'd3, 1'b1, 1'b1, 1'b1, 4'd1, 2'd2, "R5 nyet rx pending");
        read_expect(8'h08, "R5 stat");

        send(2'd3, 1'b1, 1'b1, 1'b0, 4'd1, 2'd2, "R6 nyet tx pending");
        read_expect(8'h02, "R6 stat");

        send(2'd3, 1'b1, 1'b1, 1'b1, 4'd0, 2'd3, "R7 error over mode 3");
        read_expect(8'h20, "R7 stat mode 3");
        send(2'd1, 1'b0, 1'b0, 1'b0, 4'd15, 2'd3, "R7 error in mode 1");
        read_expect(8'h20, "R7 stat mode 1");

        send(2'd0, 1'b1, 1'b0, 1'b0, 4'd1, 2'd0, "R9 mode 0");
        send(2'd2, 1'b1, 1'b0, 1'b0, 4'd3, 2'd0, "R9 mode 2");
        read_expect(8'h00, "R9 stat unchanged");

        @(negedge clk);
        resume_evt = 1'b1;
        @(negedge clk);
        resume_evt = 1'b0;
        read_expect(8'h10, "R10 resume bit");

        send(2'd3, 1'b1, 1'b0, 1'b0, 4'd1, 2'd1, "R11 accumulate ack");
        send(2'd3, 1'b1, 1'b0, 1'b1, 4'd1, 2'd2, "R11 accumulate nocmp");
        read_expect(8'h0C, "R11 bits accumulate");

        // A read and a token in the same cycle: the new bit must survive.
        @(negedge clk);
        lpm_mode = 2'd1; tok_link_state = 4'd1; tok_valid = 1'b1; stat_rd = 1'b1;
        exp_q.push_back(2'd3);
        tag_q.push_back("R11 same-cycle token");
        #1 check("R11 read before set", stat, 8'h00);
        @(negedge clk);
        tok_valid = 1'b0; stat_rd = 1'b0;
        read_expect(8'h01, "R11 set survives clear");

        repeat (2) @(negedge clk);
        check("R8 all handshakes seen", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule